// File: doc/BRIEF.md
# Serial Level Register Front End for a Multichannel Volume Controller

This block is the digital front end of a multichannel volume controller. A host sends two-byte transactions over a serial link made of a shift clock, a data line, an active-low write enable that gates shifting, and an active-low load strobe that commits what was shifted. The block samples all four lines into the system clock domain, assembles bytes, and decodes each one as either a target-select byte or a level byte. On each rising edge of the load strobe it moves the staged values into holding registers.

The holding registers drive one 7-bit master attenuation code, six 5-bit channel gain codes and one mute flag per target. The analog level circuitry reads these outputs. The block supports two wiring modes. In the first, write and load are tied to one strobe, and the end of that strobe both stops shifting and commits. In the second, a separate load pulse commits after write has risen. Reset leaves the master muted, so the whole output stays silent until a host sends an unmute.

Top module: `vol_serial_if`

## Requirements
- R1: After reset, master_mute_o is 1, every ch_mute_o bit is 0, and master_lvl_o and every channel code are 0.
- R2: Bits are shifted MSB first, one bit per falling edge of sclk_i, and only while wr_ni is low. Clock edges while wr_ni is high change no staged state. A rising edge of wr_ni discards a partly received byte, so the next byte starts at its MSB.
- R3: The outputs change only in response to a rising edge of ld_ni. Bytes shifted in with write low leave the outputs unchanged until that edge.
- R4: A byte with bit 7 = 1 is a select byte. Bits [6:4] choose the target: 0 is the master, n = 1..6 is channel n, and 7 selects nothing. Bit 0 is the mute control (0 = mute, 1 = unmute), applied to the selected target at each commit, even when no level byte followed.
- R5: A byte with bit 7 = 0 is a level byte. The master takes bits [6:0] and a channel takes bits [4:0].
- R6: With select code 7, a commit changes no output, whatever the mute bit and level bytes are.
- R7: The last select byte is kept across transactions. When several level bytes follow it, the last one is committed, and a later transaction that carries only a level byte updates the same target.
- R8: A level byte received before any select byte since reset is ignored.
- R9: When the last falling clock edge of a byte and the strobe's rising edge reach the system clock domain in the same cycle, the commit includes that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial shift clock, data taken on its falling edge |
| sdata_i | input | 1 | Serial data, MSB first |
| wr_ni | input | 1 | Write enable, active low; shifting only while low |
| ld_ni | input | 1 | Load strobe; rising edge commits |
| master_lvl_o | output | 7 | Master attenuation code |
| master_mute_o | output | 1 | Master mute, 1 = muted |
| ch_lvl_o | output | 30 | Six 5-bit channel gain codes, channel n at bits [5n-1:5n-5] |
| ch_mute_o | output | 6 | Channel mutes, bit n-1 for channel n |

## Verification
Two things can fall in the same system cycle: completing a byte and committing on the load edge. When they coincide, the commit has to use the byte that is just finishing, not the staged value from the cycle before. The bench provokes this in 3-wire mode by dropping sclk_i for the last bit at the same instant that it raises the shared strobe. It does this once for a level byte and once for a select byte. It then judges the result by comparing the target's level and mute outputs with the values the requirements predict.

// File: rtl/vol_if_pkg.sv
package vol_if_pkg;
  localparam int BYTE_W  = 8;
  localparam int SEL_W   = 3;
  localparam int SEL_LSB = 4;
  localparam logic [SEL_W-1:0] SEL_MASTER = '0;
  localparam logic [SEL_W-1:0] SEL_NONE   = '1;

  typedef struct packed {
    logic              addr_vld;
    logic [SEL_W-1:0]  sel;
    logic              unmute;
    logic              lvl_vld;
    logic [BYTE_W-2:0] lvl;
  } stage_t;
endpackage

// File: rtl/vol_sync.sv
module vol_sync #(
  parameter int          W       = 4,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= RST_VAL;
        else         pipe_q <= async_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
        else         pipe_q <= {pipe_q[STAGES-2:0], async_i};
    end
  endgenerate

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/vol_byte_shifter.sv
module vol_byte_shifter
  import vol_if_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   sclk_fall_i,
  input  logic   sdata_i,
  input  logic   wr_gate_ni,
  input  logic   wr_rise_i,
  input  logic   commit_i,
  output stage_t stage_nxt_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [BYTE_W-1:0] shreg_q, shreg_nxt;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic              shift_en, byte_done;
  stage_t            stage_q, stage_nxt;

  assign shift_en  = sclk_fall_i & ~wr_gate_ni;
  assign shreg_nxt = {shreg_q[BYTE_W-2:0], sdata_i};
  assign byte_done = shift_en && (bit_cnt_q == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q   <= '0;
      bit_cnt_q <= '0;
    end else begin
      if (shift_en) shreg_q <= shreg_nxt;
      if (wr_rise_i)     bit_cnt_q <= '0;   // realign on end of write
      else if (shift_en) bit_cnt_q <= byte_done ? '0 : bit_cnt_q + 1'b1;
    end
  end

  // decode of the byte completing this cycle, forwarded to the commit path
  always_comb begin
    stage_nxt = stage_q;
    if (byte_done) begin
      if (shreg_nxt[BYTE_W-1]) begin
        stage_nxt.addr_vld = 1'b1;
        stage_nxt.sel      = shreg_nxt[SEL_LSB +: SEL_W];
        stage_nxt.unmute   = shreg_nxt[0];
        stage_nxt.lvl_vld  = 1'b0;
      end else if (stage_q.addr_vld) begin
        stage_nxt.lvl_vld  = 1'b1;
        stage_nxt.lvl      = shreg_nxt[BYTE_W-2:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_nxt;
      if (commit_i) stage_q.lvl_vld <= 1'b0;
    end
  end

  assign stage_nxt_o = stage_nxt;

  AST_NO_SHIFT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_gate_ni && !commit_i) |=> $stable(stage_q)) else $error("shift while gated"); // R2
  AST_LVL_NEEDS_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q.lvl_vld |-> stage_q.addr_vld) else $error("level without select"); // R8
endmodule

// File: rtl/vol_level_bank.sv
module vol_level_bank
  import vol_if_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int MASTER_W = 7,
  parameter int CH_W     = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   commit_i,
  input  stage_t                 stage_i,
  output logic [MASTER_W-1:0]    master_lvl_o,
  output logic                   master_mute_o,
  output logic [NUM_CH*CH_W-1:0] ch_lvl_o,
  output logic [NUM_CH-1:0]      ch_mute_o
);
  logic hit_master;
  assign hit_master = commit_i && stage_i.addr_vld && (stage_i.sel == SEL_MASTER);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_lvl_o  <= '0;
      master_mute_o <= 1'b1;
    end else if (hit_master) begin
      master_mute_o <= ~stage_i.unmute;
      if (stage_i.lvl_vld) master_lvl_o <= stage_i.lvl[MASTER_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = commit_i && stage_i.addr_vld && (stage_i.sel == SEL_W'(g + 1));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ch_lvl_o[g*CH_W +: CH_W] <= '0;
        ch_mute_o[g]             <= 1'b0;
      end else if (hit) begin
        ch_mute_o[g] <= ~stage_i.unmute;
        if (stage_i.lvl_vld) ch_lvl_o[g*CH_W +: CH_W] <= stage_i.lvl[CH_W-1:0];
      end
    end
  end

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(master_lvl_o) && $stable(master_mute_o) &&
                   $stable(ch_lvl_o) && $stable(ch_mute_o))) else $error("update without load"); // R3
  AST_NONE_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && stage_i.sel == SEL_NONE) |=> ($stable(master_lvl_o) && $stable(master_mute_o) &&
                   $stable(ch_lvl_o) && $stable(ch_mute_o))) else $error("no-select changed state"); // R6
  AST_MASTER_SEL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && stage_i.sel != SEL_MASTER) |=> ($stable(master_lvl_o) && $stable(master_mute_o)))
    else $error("master hit by channel select"); // R4
endmodule

// File: rtl/vol_serial_if.sv
module vol_serial_if
  import vol_if_pkg::*;
#(
  parameter int NUM_CH      = 6,
  parameter int MASTER_W    = 7,
  parameter int CH_W        = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   sclk_i,
  input  logic                   sdata_i,
  input  logic                   wr_ni,
  input  logic                   ld_ni,
  output logic [MASTER_W-1:0]    master_lvl_o,
  output logic                   master_mute_o,
  output logic [NUM_CH*CH_W-1:0] ch_lvl_o,
  output logic [NUM_CH-1:0]      ch_mute_o
);
  localparam int IN_W = 4;

  logic [IN_W-1:0] in_s;
  logic            sclk_s, sdata_s, wr_s, ld_s;
  logic            sclk_prev_q, wr_prev_q, ld_prev_q;
  logic            sclk_fall, wr_rise, ld_rise;
  stage_t          stage_nxt;

  vol_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b1011)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sclk_i, sdata_i, wr_ni, ld_ni}),
    .sync_o  (in_s)
  );
  assign {sclk_s, sdata_s, wr_s, ld_s} = in_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_prev_q <= 1'b1;
      wr_prev_q   <= 1'b1;
      ld_prev_q   <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      wr_prev_q   <= wr_s;
      ld_prev_q   <= ld_s;
    end
  end

  assign sclk_fall = sclk_prev_q & ~sclk_s;
  assign wr_rise   = wr_s & ~wr_prev_q;
  assign ld_rise   = ld_s & ~ld_prev_q;

  // gate on delayed write so a final clock edge coinciding with write rise still shifts
  vol_byte_shifter u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_fall_i (sclk_fall),
    .sdata_i     (sdata_s),
    .wr_gate_ni  (wr_prev_q),
    .wr_rise_i   (wr_rise),
    .commit_i    (ld_rise),
    .stage_nxt_o (stage_nxt)
  );

  vol_level_bank #(.NUM_CH(NUM_CH), .MASTER_W(MASTER_W), .CH_W(CH_W)) u_bank (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .commit_i      (ld_rise),
    .stage_i       (stage_nxt),
    .master_lvl_o  (master_lvl_o),
    .master_mute_o (master_mute_o),
    .ch_lvl_o      (ch_lvl_o),
    .ch_mute_o     (ch_mute_o)
  );

  AST_COMMIT_IS_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_rise |=> !ld_rise) else $error("commit lasted two cycles"); // R3
endmodule

// File: tb/vol_serial_if_tb.sv
module vol_serial_if_tb;
  localparam int NCH = 6;
  localparam int CW  = 5;

  logic clk = 0;
  logic rst_ni = 0;
  logic sclk = 1, sdata = 0, wr_n = 1, ld_n = 1;
  logic [6:0]        master_lvl;
  logic              master_mute;
  logic [NCH*CW-1:0] ch_lvl;
  logic [NCH-1:0]    ch_mute;

  always #2 clk = ~clk;

  vol_serial_if u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .wr_ni(wr_n), .ld_ni(ld_n), .master_lvl_o(master_lvl), .master_mute_o(master_mute),
    .ch_lvl_o(ch_lvl), .ch_mute_o(ch_mute)
  );

  typedef struct {
    logic [6:0]        m_lvl;
    logic              m_mute;
    logic [NCH*CW-1:0] c_lvl;
    logic [NCH-1:0]    c_mute;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  int   n_vec = 0, n_bad = 0;
  bit   done = 0;

  logic [6:0]    e_m = 0;
  logic          e_mm = 1;
  logic [CW-1:0] e_c [NCH];
  logic [NCH-1:0] e_cm = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [NCH*CW-1:0] flat_c();
    logic [NCH*CW-1:0] f;
    for (int i = 0; i < NCH; i++) f[i*CW +: CW] = e_c[i];
    return f;
  endfunction

  task automatic compare_now(input string req);
    chk(master_lvl === e_m,  req, "master_lvl", 32'(master_lvl), 32'(e_m));
    chk(master_mute === e_mm, req, "master_mute", 32'(master_mute), 32'(e_mm));
    chk(ch_lvl === flat_c(), req, "ch_lvl", 32'(ch_lvl), 32'(flat_c()));
    chk(ch_mute === e_cm,    req, "ch_mute", 32'(ch_mute), 32'(e_cm));
  endtask

  // monitor: pops expected snapshot once the commit has propagated
  initial begin
    forever begin
      exp_t it;
      wait (exp_q.size() != 0);
      repeat (10) @(negedge clk);
      it = exp_q.pop_front();
      chk(master_lvl === it.m_lvl,  it.req, "master_lvl", 32'(master_lvl), 32'(it.m_lvl));
      chk(master_mute === it.m_mute, it.req, "master_mute", 32'(master_mute), 32'(it.m_mute));
      chk(ch_lvl === it.c_lvl,      it.req, "ch_lvl", 32'(ch_lvl), 32'(it.c_lvl));
      chk(ch_mute === it.c_mute,    it.req, "ch_mute", 32'(ch_mute), 32'(it.c_mute));
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic push(input string req);
    exp_t it;
    it.m_lvl = e_m; it.m_mute = e_mm; it.c_lvl = flat_c(); it.c_mute = e_cm; it.req = req;
    exp_q.push_back(it);
    tick(16);
  endtask

  // nbits bits of b, MSB first; if strobe_end, last fall coincides with strobe rise
  task automatic send_bits(input logic [7:0] b, input int nbits, input bit strobe_end);
    for (int i = 7; i > 7 - nbits; i--) begin
      sdata = b[i];
      tick(4);
      sclk = 0;
      if (strobe_end && i == 8 - nbits) begin wr_n = 1; ld_n = 1; end
      tick(4);
      sclk = 1;
    end
  endtask

  task automatic start3(); wr_n = 0; ld_n = 0; tick(3); endtask
  task automatic end3();   tick(3); wr_n = 1; ld_n = 1; tick(2); endtask
  task automatic load_pulse(); ld_n = 0; tick(4); ld_n = 1; tick(2); endtask

  initial begin
    for (int i = 0; i < NCH; i++) e_c[i] = '0;
    tick(5);
    rst_ni = 1;
    tick(3);
    @(negedge clk);
    compare_now("R1");

    // R8: level byte with no prior select
    start3(); send_bits(8'h33, 8, 0); end3();
    push("R8");

    // R4 R5: master select unmute, level 0x55 (3-wire)
    start3(); send_bits(8'h81, 8, 0); send_bits(8'h55, 8, 0); end3();
    e_m = 7'h55; e_mm = 0; push("R5");

    // R5: channel 3 takes low five bits of 0x7A
    start3(); send_bits(8'hB1, 8, 0); send_bits(8'h7A, 8, 0); end3();
    e_c[2] = 5'h1A; push("R5");

    // R3: 4-wire, hold after write, commit on load
    wr_n = 0; tick(3); send_bits(8'hE1, 8, 0); send_bits(8'h13, 8, 0); tick(3); wr_n = 1;
    tick(12); @(negedge clk); compare_now("R3");
    tick(1); load_pulse();
    e_c[5] = 5'h13; push("R3");

    // R6: select 7 with mute bit 0 and a level
    start3(); send_bits(8'hF0, 8, 0); send_bits(8'h00, 8, 0); end3();
    push("R6");

    // R7: two levels after one select; mute channel 1
    start3(); send_bits(8'h90, 8, 0); send_bits(8'h05, 8, 0); send_bits(8'h0C, 8, 0); end3();
    e_c[0] = 5'h0C; e_cm[0] = 1; push("R7");
    // R7: level-only transaction reuses kept select
    start3(); send_bits(8'h1F, 8, 0); end3();
    e_c[0] = 5'h1F; push("R7");

    // R2: partial byte dropped, next transaction realigned
    start3(); send_bits(8'hFF, 5, 0); end3();
    push("R2");
    start3(); send_bits(8'h81, 8, 0); send_bits(8'h22, 8, 0); end3();
    e_m = 7'h22; e_mm = 0; push("R2");
    // R2: clocking with write high shifts nothing; lone load changes nothing
    send_bits(8'hC1, 8, 0); send_bits(8'h09, 8, 0); tick(3); load_pulse();
    push("R2");

    // R9: last fall of level byte coincident with strobe rise
    start3(); send_bits(8'hA1, 8, 0); send_bits(8'h0E, 8, 1); tick(2);
    e_c[1] = 5'h0E; push("R9");
    // R9 R4: select-only, mute master, coincident end
    start3(); send_bits(8'h80, 8, 1); tick(2);
    e_mm = 1; push("R9");
    // R4: select-only unmute keeps level
    start3(); send_bits(8'h81, 8, 0); end3();
    e_mm = 0; push("R4");

    wait (exp_q.size() == 0);
    tick(12);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule